// File: doc/BRIEF.md
# Masked Edge-Triggered Status Interrupt Unit

This block collects event pulses from the rest of a chip into a 16-bit status word and turns them into a single active-low interrupt line for a host. The host reaches it through a simple addressed register port. Each event pulse sets a sticky flag bit. A write-only mask register chooses which flags may raise the summary request bit at the top of the status word. The interrupt pin is driven from that summary bit, gated by the top mask bit. The summary bit is raised only when a masked flag makes a fresh 0-to-1 transition. A flag that is already set, or a mask that is opened over flags that are already set, raises nothing.

Reading the status word returns the value it held before the access. The same clock edge clears every sticky flag and the summary bit. Bit 0 is not sticky. It is a live "ready" indication for a programming register. A host write to that register clears it, and a completion pulse from the internal consumer sets it again. A data-less command address returns the whole unit to its reset state.

Top module: `status_irq_unit`

## Requirements
- R1: After rst_n is deasserted, bus_rdata is 0, irq_n is 1, prog_load is 0 and a status read returns 0x0001.
- R2: A one-cycle pulse on event_in[k] (k from 1 to 14) sets status bit k, and the bit stays set until a status read.
- R3: A read access (bus_sel=1, bus_we=0) at address 0xC6 places the status value from before that clock edge on bus_rdata from the next cycle. The same edge clears status bits 14..1 and the summary bit 15.
- R4: Status bit 0 is 1 after reset and is not cleared by a status read. A write to address 0xC8 clears it and a cons_ack pulse sets it. When both happen in the same cycle, the write wins.
- R5: Status bit 15 is set when any status bit k (0 to 14) goes from 0 to 1 while mask bit k is 1. A pulse on a flag that is already set does not set bit 15.
- R6: irq_n is 0 exactly when status bit 15 and mask bit 15 are both 1.
- R7: Writing the mask register at address 0xCE does not set status bit 15 for flags that are already set.
- R8: An event that arrives in the same cycle as a status read leaves its flag set after the read, and sets bit 15 again if that flag is unmasked.
- R9: Any write to address 0x01, whatever the data, clears the mask, status bits 15..1 and the request, and sets status bit 0.
- R10: A write to address 0xC8 places the written data on prog_word and pulses prog_load high for exactly one cycle, starting the cycle after the write.
- R11: A read at any address other than 0xC6 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after a read |
| event_in | input | 14 | Flag set pulses; bit k sets status bit k (k = 1..14) |
| cons_ack | input | 1 | Programming consumer has taken the word; sets status bit 0 |
| prog_word | output | 16 | Last word written to the programming register |
| prog_load | output | 1 | One-cycle pulse when prog_word has been updated |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event that lands in the same clock as the clearing read. The flag must survive, and the request must fire again while the returned value still shows the old state. The bench drives the event pulse inside the read task itself, so the two share one edge. It then reads a second time to confirm that the flag and bit 15 are back. Requests that are raised without a fresh edge are provoked on purpose: the bench re-pulses a flag that is already set, and it opens the mask over flags that are already pending. The programming write is also made to coincide with the consumer's acknowledge.

// File: rtl/status_irq_unit.sv
module status_irq_unit #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_RESET  = 8'h01,
  parameter logic [AW-1:0] ADDR_STATUS = 8'hC6,
  parameter logic [AW-1:0] ADDR_PROG   = 8'hC8,
  parameter logic [AW-1:0] ADDR_MASK   = 8'hCE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-2:1] event_in,
  input  logic          cons_ack,
  output logic [DW-1:0] prog_word,
  output logic          prog_load,
  output logic          irq_n
);
  localparam int NEV = DW - 2;

  logic [DW-1:0]  mask_q;
  logic [DW-2:1]  flag_q;
  logic           irq_q;
  logic           rdy_q;

  wire rd_any  = bus_sel & ~bus_we;
  wire wr_any  = bus_sel &  bus_we;
  wire rd_stat = rd_any & (bus_addr == ADDR_STATUS);
  wire wr_mask = wr_any & (bus_addr == ADDR_MASK);
  wire wr_prog = wr_any & (bus_addr == ADDR_PROG);
  wire cmd_rst = wr_any & (bus_addr == ADDR_RESET);

  wire [DW-1:0] status = {irq_q, flag_q, rdy_q};

  wire [DW-2:1] flag_kept = rd_stat ? '0 : flag_q;
  wire [DW-2:1] flag_rise = event_in & ~flag_kept;
  wire          rdy_rise  = cons_ack & ~wr_prog & ~rdy_q;
  wire          hit       = |({flag_rise, rdy_rise} & mask_q[DW-2:0]);

  assign irq_n = ~(irq_q & mask_q[DW-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
      rdy_q  <= 1'b1;
    end else if (cmd_rst) begin
      mask_q <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      if (wr_mask) mask_q <= bus_wdata;
      flag_q <= flag_kept | event_in;
      if (hit)          irq_q <= 1'b1;
      else if (rd_stat) irq_q <= 1'b0;
      if (wr_prog)       rdy_q <= 1'b0;
      else if (cons_ack) rdy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      prog_word <= '0;
      prog_load <= 1'b0;
    end else begin
      if (rd_any) bus_rdata <= rd_stat ? status : '0;
      if (wr_prog) prog_word <= bus_wdata;
      prog_load <= wr_prog;
    end
  end

  logic unused_nev;
  assign unused_nev = (NEV == 0);
endmodule

// File: rtl/status_irq_chk.sv
module status_irq_chk #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_RESET  = 8'h01,
  parameter logic [AW-1:0] ADDR_STATUS = 8'hC6,
  parameter logic [AW-1:0] ADDR_PROG   = 8'hC8,
  parameter logic [AW-1:0] ADDR_MASK   = 8'hCE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-2:1] event_in,
  input logic          cons_ack,
  input logic          irq_n,
  input logic          prog_load,
  input logic [DW-1:0] mask_q,
  input logic [DW-2:1] flag_q,
  input logic          irq_q,
  input logic          rdy_q
);
  wire c_rd   = bus_sel & ~bus_we & (bus_addr == ADDR_STATUS);
  wire c_prog = bus_sel &  bus_we & (bus_addr == ADDR_PROG);
  wire c_mask = bus_sel &  bus_we & (bus_addr == ADDR_MASK);
  wire c_rst  = bus_sel &  bus_we & (bus_addr == ADDR_RESET);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && event_in == '0 && !cons_ack) |=> (flag_q == '0 && !irq_q && irq_n));

  assert_event_survives_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd |=> (flag_q == $past(event_in)));

  assert_ready_not_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && rdy_q) |=> rdy_q);

  assert_prog_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_prog |=> (prog_load && !rdy_q));

  assert_mask_no_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mask && !irq_q && event_in == '0 && !cons_ack) |=> !irq_q);

  assert_raise_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && (event_in & mask_q[DW-2:1]) == '0 && !(cons_ack && mask_q[0])) |=> !irq_q);

  assert_general_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst |=> (mask_q == '0 && flag_q == '0 && !irq_q && rdy_q && irq_n));
endmodule

bind status_irq_unit status_irq_chk #(
  .DW(DW), .AW(AW), .ADDR_RESET(ADDR_RESET), .ADDR_STATUS(ADDR_STATUS),
  .ADDR_PROG(ADDR_PROG), .ADDR_MASK(ADDR_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .event_in(event_in), .cons_ack(cons_ack),
  .irq_n(irq_n), .prog_load(prog_load), .mask_q(mask_q), .flag_q(flag_q),
  .irq_q(irq_q), .rdy_q(rdy_q)
);

// File: tb/status_irq_unit_tb.sv
`timescale 1ns/1ps
module status_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [14:1] event_in = '0;
  logic        cons_ack = 1'b0;
  logic [15:0] prog_word;
  logic        prog_load;
  logic        irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  status_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .event_in(event_in), .cons_ack(cons_ack), .prog_word(prog_word),
    .prog_load(prog_load), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  function automatic logic [14:1] evb(input int k);
    logic [14:1] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic ack);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; cons_ack = ack;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; cons_ack = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [14:1] ev, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; event_in = ev;
    @(negedge clk);
    bus_sel = 1'b0; event_in = '0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [14:1] ev, input logic ack);
    event_in = ev; cons_ack = ack;
    @(negedge clk);
    event_in = '0; cons_ack = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 irq_n", {15'h0, irq_n}, 16'h1);
    check("R1 prog_load", {15'h0, prog_load}, 16'h0);
    do_read(8'hC6, '0, d);
    check("R1 status", d, 16'h0001);
  endtask

  task automatic t_sticky;
    logic [15:0] d;
    pulse(evb(3), 1'b0);
    @(negedge clk);
    do_read(8'hC6, '0, d);
    check("R2 sticky bit3", d, 16'h0009);
    do_read(8'hC6, '0, d);
    check("R3 cleared", d, 16'h0001);
  endtask

  task automatic t_irq_mask;
    logic [15:0] d;
    do_write(8'hCE, 16'h8010, 1'b0);
    pulse(evb(4), 1'b0);
    check("R5 R6 irq asserted", {15'h0, irq_n}, 16'h0);
    do_read(8'hC6, '0, d);
    check("R3 old value", d, 16'h8011);
    check("R3 irq released", {15'h0, irq_n}, 16'h1);
    pulse(evb(5), 1'b0);
    check("R5 unmasked flag", {15'h0, irq_n}, 16'h1);
    do_write(8'hCE, 16'h8030, 1'b0);
    check("R7 mask open", {15'h0, irq_n}, 16'h1);
    pulse(evb(5), 1'b0);
    check("R5 already set", {15'h0, irq_n}, 16'h1);
    do_read(8'hC6, '0, d);
    check("R2 R7 status", d, 16'h0021);
  endtask

  task automatic t_gate15;
    logic [15:0] d;
    do_write(8'hCE, 16'h0010, 1'b0);
    pulse(evb(4), 1'b0);
    check("R6 gated", {15'h0, irq_n}, 16'h1);
    do_read(8'hC6, '0, d);
    check("R5 summary bit", d, 16'h8011);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    do_write(8'hCE, 16'h8010, 1'b0);
    pulse(evb(4), 1'b0);
    do_read(8'hC6, evb(4), d);
    check("R8 returned", d, 16'h8011);
    check("R8 irq again", {15'h0, irq_n}, 16'h0);
    do_read(8'hC6, '0, d);
    check("R8 flag kept", d, 16'h8011);
    do_read(8'hC6, '0, d);
    check("R3 idle", d, 16'h0001);
  endtask

  task automatic t_prog;
    logic [15:0] d;
    do_write(8'hCE, 16'h8001, 1'b0);
    do_write(8'hC8, 16'hBEEF, 1'b0);
    check("R10 load", {15'h0, prog_load}, 16'h1);
    check("R10 word", prog_word, 16'hBEEF);
    @(negedge clk);
    check("R10 one cycle", {15'h0, prog_load}, 16'h0);
    do_read(8'hC6, '0, d);
    check("R4 busy", d, 16'h0000);
    check("R4 no irq", {15'h0, irq_n}, 16'h1);
    pulse('0, 1'b1);
    check("R5 ready rise", {15'h0, irq_n}, 16'h0);
    do_read(8'hC6, '0, d);
    check("R4 R5 status", d, 16'h8001);
    do_read(8'hC6, '0, d);
    check("R4 survives read", d, 16'h0001);
    do_write(8'hC8, 16'h1234, 1'b1);
    do_read(8'hC6, '0, d);
    check("R4 write wins", d, 16'h0000);
    pulse('0, 1'b1);
    do_read(8'hC6, '0, d);
    do_read(8'hC6, '0, d);
    check("R4 restored", d, 16'h0001);
  endtask

  task automatic t_other;
    logic [15:0] d;
    do_write(8'hCE, 16'h0000, 1'b0);
    pulse(evb(2), 1'b0);
    do_read(8'hB0, '0, d);
    check("R11 other addr", d, 16'h0000);
    do_read(8'hC6, '0, d);
    check("R11 nothing cleared", d, 16'h0005);
  endtask

  task automatic t_greset;
    logic [15:0] d;
    do_write(8'hCE, 16'h8004, 1'b0);
    pulse(evb(2), 1'b0);
    check("R9 pre irq", {15'h0, irq_n}, 16'h0);
    do_write(8'hC8, 16'h0F0F, 1'b0);
    do_write(8'h01, 16'hFFFF, 1'b0);
    check("R9 irq cleared", {15'h0, irq_n}, 16'h1);
    pulse(evb(2), 1'b0);
    check("R9 mask cleared", {15'h0, irq_n}, 16'h1);
    do_read(8'hC6, '0, d);
    check("R9 status", d, 16'h0005);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_irq_mask();
    t_gate15();
    t_collide();
    t_prog();
    t_other();
    t_greset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule